// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block sits between a group of device controllers on a shared I/O bus and the CPU. Any controller with work pending raises a common interrupt-request line. The block notices this and starts a poll. The poll token visits the chain positions one per cycle, starting at position 0. It stops at the first position whose controller reports a pending request. Position 0 has the highest priority. Once the poll finds a winner, the block raises an external-interrupt line to the CPU.

The CPU answers with an acknowledge. On that acknowledge the winner's device number is latched into an address register, and the interrupt line drops. The number of a device is its chain position. When the CPU asserts its read strobe, the register is driven onto the CPU data bus. A request that arrives during a poll or while the block waits for acknowledge is only taken up after the sequencer has spent a cycle in idle.

Top module: `poll_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, the address register is 0, `ext_int_o` is 0, `poll_o` is all zero and the sequencer is idle.
- R2: When `int_req_i` is sampled high in idle, polling starts on the next cycle at position 0. `poll_o` is one-hot on the position under poll, with bit k meaning position k. The poll advances by one position per cycle toward higher indices.
- R3: Polling stops at the first polled position k whose `dev_pend_i[k]` is high, so the lowest pending index wins. `ext_int_o` rises on the following cycle, and `poll_o` is zero from then on.
- R4: `ext_int_o` stays high until `int_ack_i` is sampled high. It is low on the next cycle, and that cycle is spent idle with `poll_o` zero.
- R5: An acknowledge sampled while `ext_int_o` is high loads the winner's position number into the address register. An acknowledge at any other time leaves the register unchanged.
- R6: `s_bus_o` equals the address register, zero-extended, whenever `rd_en_i` is high, and is zero otherwise. A read in the same cycle as an accepted acknowledge returns the previous register value.
- R7: If `int_req_i` is sampled low during polling, the sequence returns to idle without raising `ext_int_o`. This holds even in the cycle where a pending position is hit. The register is unchanged.
- R8: If the poll leaves the last position without a hit, the sequencer returns to idle without raising `ext_int_o`.
- R9: Changes to `dev_pend_i` while waiting for acknowledge do not alter the latched winner. An `int_req_i` still high across the acknowledge starts a new poll one idle cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_req_i | input | 1 | Shared interrupt request from the controllers |
| dev_pend_i | input | N_DEV | Pending flag reported by each chain position when polled |
| poll_o | output | N_DEV | One-hot poll token, bit k polls position k |
| int_ack_i | input | 1 | Interrupt acknowledge from the CPU |
| ext_int_o | output | 1 | External interrupt to the CPU |
| rd_en_i | input | 1 | CPU read strobe for the address register |
| s_bus_o | output | DATA_W | CPU data bus, carries the device number when read |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the acknowledge and a CPU read of the address register. The bench asserts both strobes together and expects the bus to show the old number in that cycle and the new one in the next. The second pair is a poll hit and the fall of the request line. The bench waits until the token reaches the pending position and then drops the request, and expects an abort with no interrupt and an unchanged register. A reference model that advances each clock judges every cycle of both cases.

// File: rtl/poll_irq_pkg.sv
package poll_irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/poll_irq_chain.sv
// Poll token decode and per-position hit detect.
module poll_irq_chain #(
  parameter int N_DEV = 8,
  parameter int POS_W = 3
) (
  input  logic             active_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [N_DEV-1:0] pend_i,
  output logic [N_DEV-1:0] poll_o,
  output logic             hit_o
);
  logic [N_DEV-1:0] poll_vec;
  logic [N_DEV-1:0] hit_vec;

  for (genvar k = 0; k < N_DEV; k++) begin : g_pos
    assign poll_vec[k] = active_i && (pos_i == POS_W'(k));
    assign hit_vec[k]  = poll_vec[k] & pend_i[k];
  end

  assign poll_o = poll_vec;
  assign hit_o  = |hit_vec;
endmodule

// File: rtl/poll_irq_seq.sv
module poll_irq_seq
  import poll_irq_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int POS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_req_i,
  input  logic             ack_i,
  input  logic             hit_i,
  output seq_st_e          st_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] win_o,
  output logic             load_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_DEV - 1);

  seq_st_e          st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] win_q, win_d;

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    win_d = win_q;
    unique case (st_q)
      ST_IDLE: begin
        if (int_req_i) begin
          st_d  = ST_POLL;
          pos_d = '0;
        end
      end
      ST_POLL: begin
        if (!int_req_i) begin
          st_d = ST_IDLE;          // request withdrawn, abort
        end else if (hit_i) begin
          st_d  = ST_WAIT;
          win_d = pos_q;
        end else if (pos_q == LAST_POS) begin
          st_d = ST_IDLE;          // chain exhausted
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (ack_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      pos_q <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
      win_q <= win_d;
    end
  end

  assign st_o   = st_q;
  assign pos_o  = pos_q;
  assign win_o  = win_q;
  assign load_o = (st_q == ST_WAIT) && ack_i;
endmodule

// File: rtl/poll_irq_addr_reg.sv
// Device-number register and CPU bus read mux.
module poll_irq_addr_reg #(
  parameter int POS_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [POS_W-1:0]  win_i,
  input  logic              rd_en_i,
  output logic [POS_W-1:0]  ioa_o,
  output logic [DATA_W-1:0] bus_o
);
  localparam int PAD_W = DATA_W - POS_W;

  logic [POS_W-1:0] ioa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ioa_q <= '0;
    else if (load_i) ioa_q <= win_i;
  end

  assign ioa_o = ioa_q;
  assign bus_o = rd_en_i ? {{PAD_W{1'b0}}, ioa_q} : '0;
endmodule

// File: rtl/poll_irq_ctrl.sv
module poll_irq_ctrl
  import poll_irq_pkg::*;
#(
  parameter int N_DEV  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_req_i,
  input  logic [N_DEV-1:0]  dev_pend_i,
  output logic [N_DEV-1:0]  poll_o,
  input  logic              int_ack_i,
  output logic              ext_int_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] s_bus_o
);
  localparam int POS_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  seq_st_e          st_w;
  logic [POS_W-1:0] pos_w;
  logic [POS_W-1:0] win_w;
  logic [POS_W-1:0] ioa_w;
  logic             load_w;
  logic             hit_w;

  poll_irq_seq #(.N_DEV(N_DEV), .POS_W(POS_W)) seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_req_i (int_req_i),
    .ack_i     (int_ack_i),
    .hit_i     (hit_w),
    .st_o      (st_w),
    .pos_o     (pos_w),
    .win_o     (win_w),
    .load_o    (load_w)
  );

  poll_irq_chain #(.N_DEV(N_DEV), .POS_W(POS_W)) chain_i (
    .active_i (st_w == ST_POLL),
    .pos_i    (pos_w),
    .pend_i   (dev_pend_i),
    .poll_o   (poll_o),
    .hit_o    (hit_w)
  );

  poll_irq_addr_reg #(.POS_W(POS_W), .DATA_W(DATA_W)) areg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_w),
    .win_i   (win_w),
    .rd_en_i (rd_en_i),
    .ioa_o   (ioa_w),
    .bus_o   (s_bus_o)
  );

  assign ext_int_o = (st_w == ST_WAIT);
endmodule

// File: rtl/poll_irq_chk.sv
module poll_irq_chk #(
  parameter int N_DEV  = 8,
  parameter int DATA_W = 16,
  parameter int POS_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_req_i,
  input logic [N_DEV-1:0]  dev_pend_i,
  input logic [N_DEV-1:0]  poll_o,
  input logic              int_ack_i,
  input logic              ext_int_o,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] s_bus_o,
  input logic [POS_W-1:0]  ioa_i
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!ext_int_o && poll_o == '0 && ioa_i == '0);
    end
  end

  // R2
  poll_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(poll_o));

  // R3
  hit_raises_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_i && |(poll_o & dev_pend_i)) |=> (ext_int_o && poll_o == '0));

  // R4
  int_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_int_o && !int_ack_i) |=> ext_int_o);

  // R4
  ack_drops_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_int_o && int_ack_i) |=> (!ext_int_o && poll_o == '0));

  // R5
  ioa_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_int_o && int_ack_i) |=> $stable(ioa_i));

  // R6
  bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (s_bus_o == '0));

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|poll_o && !int_req_i) |=> (!ext_int_o && poll_o == '0));
endmodule

bind poll_irq_ctrl poll_irq_chk #(
  .N_DEV(N_DEV), .DATA_W(DATA_W), .POS_W(POS_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .int_req_i  (int_req_i),
  .dev_pend_i (dev_pend_i),
  .poll_o     (poll_o),
  .int_ack_i  (int_ack_i),
  .ext_int_o  (ext_int_o),
  .rd_en_i    (rd_en_i),
  .s_bus_o    (s_bus_o),
  .ioa_i      (ioa_w)
);

// File: tb/poll_irq_ctrl_tb_top.sv
module poll_irq_ctrl_tb_top;
  localparam int N = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          int_req = 1'b0;
  logic [N-1:0]  dev_pend = '0;
  logic [N-1:0]  poll;
  logic          int_ack = 1'b0;
  logic          ext_int;
  logic          rd_en = 1'b0;
  logic [DW-1:0] s_bus;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit saw_ext = 1'b0;

  always #2 clk = ~clk;

  poll_irq_ctrl #(.N_DEV(N), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .int_req_i(int_req), .dev_pend_i(dev_pend),
    .poll_o(poll), .int_ack_i(int_ack), .ext_int_o(ext_int),
    .rd_en_i(rd_en), .s_bus_o(s_bus)
  );

  // Reference model: 0 idle, 1 polling, 2 waiting for acknowledge
  int m_state = 0, m_pos = 0, m_win = 0, m_ioa = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pos = 0; m_win = 0; m_ioa = 0;
    end else begin
      case (m_state)
        0: if (int_req) begin m_state = 1; m_pos = 0; end
        1: begin
          if (!int_req) m_state = 0;
          else if (dev_pend[m_pos]) begin m_win = m_pos; m_state = 2; end
          else if (m_pos == N - 1) m_state = 0;
          else m_pos = m_pos + 1;
        end
        default: if (int_ack) begin m_ioa = m_win; m_state = 0; end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] m_poll;
      m_poll = (m_state == 1) ? (N'(1) << m_pos) : '0;
      check(ext_int === (m_state == 2), "R4 ext_int", int'(ext_int), int'(m_state == 2));
      check(poll === m_poll, "R2 poll", int'(poll), int'(m_poll));
      check(s_bus === (rd_en ? DW'(m_ioa) : '0), "R6 s_bus", int'(s_bus),
            rd_en ? m_ioa : 0);
      if (ext_int) saw_ext = 1'b1;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic exp_read(input int exp, input string tag);
    rd_en = 1'b1;
    @(negedge clk);
    check(s_bus === DW'(exp), tag, int'(s_bus), exp);
    step();
    rd_en = 1'b0;
  endtask

  task automatic wait_ext();
    for (int i = 0; i < 3 * N && !ext_int; i++) step();
  endtask

  task automatic run_int(input logic [N-1:0] pend, input int exp_win, input string tag);
    dev_pend = pend;
    int_req = 1'b1;
    wait_ext();
    check(ext_int === 1'b1, tag, int'(ext_int), 1);
    int_req = 1'b0;
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    dev_pend = '0;
    check(ext_int === 1'b0, "R4 drop after ack", int'(ext_int), 0);
    exp_read(exp_win, tag);
    step();
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check(ext_int === 1'b0 && poll === '0, "R1 in reset", int'(ext_int), 0);
    rst_n = 1'b1;
    step();
    check(ext_int === 1'b0 && poll === '0, "R1 after reset", int'(poll), 0);
    exp_read(0, "R1 register zero");

    // R2 R3 R5 single and multiple requesters
    run_int(8'b0000_1000, 3, "R3 winner pos3");
    run_int(8'b0010_0100, 2, "R3 lowest index wins");
    run_int(8'b0000_0001, 0, "R3 winner pos0");
    run_int(8'b1000_0000, 7, "R3 winner last pos");

    // R5 ack outside wait ignored
    int_ack = 1'b1; step(); int_ack = 1'b0; step();
    exp_read(7, "R5 idle ack ignored");

    // R7 abort mid-poll
    saw_ext = 1'b0;
    dev_pend = 8'b0100_0000;
    int_req = 1'b1;
    for (int i = 0; i < 8 && !poll[2]; i++) step();
    int_req = 1'b0;
    repeat (10) step();
    check(!saw_ext, "R7 abort mid-poll", int'(saw_ext), 0);
    exp_read(7, "R7 register unchanged");

    // R7 abort in the hit cycle
    saw_ext = 1'b0;
    dev_pend = 8'b0000_0010;
    int_req = 1'b1;
    for (int i = 0; i < 8 && !poll[1]; i++) step();
    int_req = 1'b0;
    repeat (4) step();
    check(!saw_ext, "R7 abort on hit cycle", int'(saw_ext), 0);
    exp_read(7, "R7 register unchanged on hit abort");

    // R8 chain exhausted
    saw_ext = 1'b0;
    dev_pend = '0;
    int_req = 1'b1;
    for (int i = 0; i < 12 && !poll[N-1]; i++) step();
    step();
    @(negedge clk);
    check(poll === '0 && !ext_int, "R8 idle after last pos", int'(poll), 0);
    step();
    int_req = 1'b0;
    repeat (3) step();
    check(!saw_ext, "R8 no interrupt", int'(saw_ext), 0);

    // R9 pending changes in wait, request held across ack; R6 read with ack
    dev_pend = 8'b0001_0000;
    int_req = 1'b1;
    wait_ext();
    dev_pend = 8'b0001_0001;
    repeat (3) step();
    check(ext_int === 1'b1, "R4 held until ack", int'(ext_int), 1);
    int_ack = 1'b1;
    rd_en = 1'b1;
    @(negedge clk);
    check(s_bus === DW'(7), "R6 read with ack returns old", int'(s_bus), 7);
    step();
    int_ack = 1'b0;
    @(negedge clk);
    check(s_bus === DW'(4), "R9 winner frozen", int'(s_bus), 4);
    check(poll === '0 && !ext_int, "R9 idle cycle after ack", int'(poll), 0);
    step();
    rd_en = 1'b0;
    @(negedge clk);
    check(poll === N'(1), "R9 new poll starts", int'(poll), 1);
    step();
    wait_ext();
    int_req = 1'b0;
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    dev_pend = '0;
    exp_read(0, "R9 second winner pos0");

    repeat (3) step();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end
endmodule